// File: doc/BRIEF.md
# Serial Phrase Command Receiver

This block takes an 8-bit command sent over a slow, host-driven serial link (a data line, a bit clock and, when configured, a frame strobe) and turns it into work for a playback controller. All three pins are asynchronous to the block and are synchronised into the fast system clock before any decision is made. A static parameter fixes the framing. In two-wire framing, a frame opens after the data line has been held low for a timed interval while the bit clock idles high. In three-wire framing, a frame is open for as long as the strobe is held low.

Bits arrive most significant first and are captured on falling edges of the bit clock. The eighth falling edge completes the command. The value zero is a stop command: it is sent on as a one-cycle pulse and also discards any command still waiting. Values 0x01 to 0xF7 select a phrase and are held in a single-entry latch, which is offered downstream through a valid/ready handshake. Values 0xF8 to 0xFF are reserved and are dropped. A ready flag, high when the latch is empty, tells the host when it may send the next phrase.

Top module: `phrase_cmd_rx`

## Requirements
- R1: During and right after reset, `nar_o` is 1, `cmd_valid_o` is 0 and `stop_o` is 0.
- R2: A frame's eight bits are captured most significant first, one per synchronised falling edge of `si_i`. After the eighth edge, a code in 0x01..0xF7 appears on `cmd_code_o` with `cmd_valid_o`=1 and `nar_o`=0.
- R3: A completed code in 0xF8..0xFF raises neither `cmd_valid_o` nor `stop_o`, and leaves `nar_o` at 1.
- R4: A completed code of 0x00 drives `stop_o` high for exactly one cycle, never sets `cmd_valid_o`, and empties a latch that was holding a code, so `nar_o` returns to 1.
- R5: While `cmd_valid_o` is 1 and `cmd_ready_i` is 0, the latched code and the valid flag hold. A cycle with both at 1 empties the latch, and `nar_o` is 1 on the next cycle.
- R6: A phrase code that completes while the latch is full and is not being accepted is dropped. The held code is unchanged.
- R7: Falling edges of `si_i` after the eighth one in a frame have no effect until a new frame starts.
- R8: Two-wire mode. A frame starts when `sd_i` falls while `si_i` is high and then stays low, with `si_i` still high, for `START_CLKS` consecutive system clocks. A shorter low pulse starts nothing. Within a frame, `sd_i` changes only while `si_i` is low.
- R9: Two-wire mode. A new qualified start before the eighth edge discards the bits already taken, and the eight edges after the new start form the code.
- R10: Three-wire mode. `si_i` and `sd_i` count only while `st_i` is low. A frame opens when `st_i` falls, and bit-clock activity while `st_i` is high has no effect.
- R11: Three-wire mode. Raising `st_i` before the eighth edge discards the partial frame. The next frame begins when `st_i` falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sd_i | input | 1 | Serial data pin, asynchronous |
| si_i | input | 1 | Serial bit clock pin, asynchronous, idles high |
| st_i | input | 1 | Frame strobe pin, active low, used in three-wire mode only |
| nar_o | output | 1 | High when the command latch is empty |
| cmd_valid_o | output | 1 | A phrase code is waiting in the latch |
| cmd_code_o | output | CODE_W | Latched phrase code |
| cmd_ready_i | input | 1 | Playback controller takes the latched code |
| stop_o | output | 1 | One-cycle stop command pulse |

## Verification
All 256 codes are swept through both framings. Each outcome is computed from the code value alone, so a decoder with an off-by-one boundary at 0xF7/0xF8 or at zero would either start playback on a reserved code or lose a phrase. The start timer is probed one clock below and exactly at its threshold; a timer that is off by one would either open frames on glitches or miss valid starts. Aborted frames, in both framings, are followed by a full frame whose code must win; a receiver that kept stale bits would latch a shifted mix. Surplus bit clocks, a second phrase against a full latch, and a stop against a pending phrase are each checked at the ports; getting these wrong shows up as a spurious second command, an overwritten code, or a stale phrase that survives a stop.

// File: rtl/phrase_rx_pkg.sv
// Shared definitions for the serial phrase command receiver.
// Assumes 8-bit command codes; the class boundaries are constants here.
package phrase_rx_pkg;

    typedef enum logic [1:0] {
        CMD_STOP     = 2'd0,
        CMD_PHRASE   = 2'd1,
        CMD_RESERVED = 2'd2
    } cmd_kind_t;

    localparam logic [7:0] STOP_VALUE    = 8'h00;
    localparam logic [7:0] RESERVED_BASE = 8'hF8;

    // Sort a completed code into stop, phrase or reserved.
    function automatic cmd_kind_t classify(input logic [7:0] code);
        if (code == STOP_VALUE)
            return CMD_STOP;
        else if (code >= RESERVED_BASE)
            return CMD_RESERVED;
        else
            return CMD_PHRASE;
    endfunction

endpackage

// File: rtl/prx_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins.
// Assumes each bit is independent (no bus coherence needed); resets to RST_VAL.
module prx_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop: captures the raw pin level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_i;
                end
            end else begin : g_next
                // Later flops: let metastability settle.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/prx_start_timer.sv
// Two-wire frame start qualifier. Arms when the data line falls while the bit
// clock is high, then counts consecutive low clocks. Fires once on the
// START_CLKS-th low sample. Assumes START_CLKS >= 2 and synchronised inputs.
module prx_start_timer #(
    parameter int START_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sd_s,
    input  logic si_s,
    input  logic sd_fall,
    output logic start_o
);
    localparam int CW = $clog2(START_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(START_CLKS - 1);

    logic          timing_q;
    logic [CW-1:0] cnt_q;

    assign start_o = timing_q && !sd_s && si_s && (cnt_q == LAST);

    // Track the length of the low pulse that began with a qualifying fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= 1'b0;
            cnt_q    <= '0;
        end else if (sd_fall && si_s) begin
            timing_q <= 1'b1;
            cnt_q    <= CW'(1);
        end else if (timing_q) begin
            if (sd_s || !si_s || cnt_q == LAST)
                timing_q <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8
    start_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (!sd_s && si_s && $past(!sd_s) && $past(si_s)));

    // R8
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/prx_framer.sv
// Frame assembler: shifts data in MSB first on gated bit-clock falls and
// reports a completed code once. The frame closes after the last bit or on
// abort. Assumes start/abort are single-cycle or level controls from the top.
module prx_framer #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              gate_i,
    input  logic              si_fall,
    input  logic              sd_s,
    output logic              done_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CODE_W - 1);

    logic              open_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] shift_q;
    logic              take;

    assign take   = open_q && gate_i && si_fall && !abort_i;
    assign done_o = take && (cnt_q == LAST_BIT);
    assign code_o = {shift_q[CODE_W-2:0], sd_s};

    // Frame state: open on start, shift on each taken edge, close at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (abort_i) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            open_q  <= 1'b1;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (take) begin
            shift_q <= code_o;
            if (cnt_q == LAST_BIT) begin
                open_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7
    bit_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(CODE_W));

    // R7
    no_edge_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> !done_o);

    // R11
    abort_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !open_q && cnt_q == '0);
endmodule

// File: rtl/prx_cmd_latch.sv
// Command decode and single-entry phrase latch with a valid/ready handshake.
// Stop codes pulse stop_o and empty the latch; reserved codes are dropped.
// Assumes done_i is a one-cycle pulse.
module prx_cmd_latch
    import phrase_rx_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [CODE_W-1:0] code_o,
    output logic              stop_o
);
    cmd_kind_t kind;
    logic      is_stop;
    logic      is_phrase;
    logic      room;

    assign kind      = classify(code_i);
    assign is_stop   = done_i && (kind == CMD_STOP);
    assign is_phrase = done_i && (kind == CMD_PHRASE);
    assign room      = !valid_o || ready_i;

    // Stop pulse register: one cycle per stop code.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_o <= 1'b0;
        else        stop_o <= is_stop;
    end

    // Latch: stop empties it, a phrase fills it if there is room, accept frees it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
        end else if (is_stop) begin
            valid_o <= 1'b0;
        end else if (is_phrase && room) begin
            valid_o <= 1'b1;
            code_o  <= code_i;
        end else if (valid_o && ready_i) begin
            valid_o <= 1'b0;
        end
    end

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (code_o != STOP_VALUE && code_o < RESERVED_BASE));

    // R5
    hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i && !is_stop |=> valid_o && $stable(code_o));

    // R4
    stop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R4
    stop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !valid_o);
endmodule

// File: rtl/phrase_cmd_rx.sv
// Top: serial phrase command receiver. Synchronises the pins, picks the
// framing scheme at elaboration, assembles codes and hands phrases downstream.
// Assumes bit-clock phases last several system clocks.
module phrase_cmd_rx #(
    parameter bit THREE_WIRE  = 1'b1,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int START_CLKS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sd_i,
    input  logic              si_i,
    input  logic              st_i,
    output logic              nar_o,
    output logic              cmd_valid_o,
    output logic [CODE_W-1:0] cmd_code_o,
    input  logic              cmd_ready_i,
    output logic              stop_o
);
    localparam int NPINS = 3;

    logic [NPINS-1:0] pins_s;
    logic             sd_s, si_s, st_s;
    logic             sd_q, si_q, st_q;
    logic             sd_fall, si_fall, st_fall;
    logic             start, abort, gate;
    logic             done;
    logic [CODE_W-1:0] code;

    prx_sync #(.W(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({st_i, si_i, sd_i}),
        .sync_o  (pins_s)
    );

    assign {st_s, si_s, sd_s} = pins_s;

    // Previous synchronised levels, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q <= 1'b1;
            si_q <= 1'b1;
            st_q <= 1'b1;
        end else begin
            sd_q <= sd_s;
            si_q <= si_s;
            st_q <= st_s;
        end
    end

    assign sd_fall = sd_q && !sd_s;
    assign si_fall = si_q && !si_s;
    assign st_fall = st_q && !st_s;

    generate
        if (THREE_WIRE) begin : g_strobe
            assign start = st_fall;
            assign abort = st_s;
            assign gate  = !st_s;

            // R10
            strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                done |-> !st_s);
        end else begin : g_timed
            prx_start_timer #(.START_CLKS(START_CLKS)) u_start (
                .clk     (clk),
                .rst_n   (rst_n),
                .sd_s    (sd_s),
                .si_s    (si_s),
                .sd_fall (sd_fall),
                .start_o (start)
            );
            assign abort = 1'b0;
            assign gate  = 1'b1;
        end
    endgenerate

    prx_framer #(.CODE_W(CODE_W)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .abort_i (abort),
        .gate_i  (gate),
        .si_fall (si_fall),
        .sd_s    (sd_s),
        .done_o  (done),
        .code_o  (code)
    );

    prx_cmd_latch #(.CODE_W(CODE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .code_i  (code),
        .ready_i (cmd_ready_i),
        .valid_o (cmd_valid_o),
        .code_o  (cmd_code_o),
        .stop_o  (stop_o)
    );

    assign nar_o = !cmd_valid_o;

    // R6
    full_latch_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i && !stop_o && !done |=> $stable(cmd_code_o));
endmodule

// File: tb/tb_phrase_cmd_rx.sv
// Bench: two receivers share the data and bit-clock pins. dut uses two-wire
// framing; dut3 uses three-wire framing with its own strobe.
module tb_phrase_cmd_rx;
    localparam int START_CLKS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sd = 1'b1, si = 1'b1, st2 = 1'b0, st3 = 1'b1;
    logic rdy2 = 1'b0, rdy3 = 1'b0;
    logic nar2, val2, stop2, nar3, val3, stop3;
    logic [7:0] code2, code3;
    int   stop2_cnt = 0, stop3_cnt = 0;
    int   tests = 0, fails = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    phrase_cmd_rx #(.THREE_WIRE(1'b0), .START_CLKS(START_CLKS)) dut (
        .clk(clk), .rst_n(rst_n), .sd_i(sd), .si_i(si), .st_i(st2),
        .nar_o(nar2), .cmd_valid_o(val2), .cmd_code_o(code2),
        .cmd_ready_i(rdy2), .stop_o(stop2));

    phrase_cmd_rx #(.THREE_WIRE(1'b1), .START_CLKS(START_CLKS)) dut3 (
        .clk(clk), .rst_n(rst_n), .sd_i(sd), .si_i(si), .st_i(st3),
        .nar_o(nar3), .cmd_valid_o(val3), .cmd_code_o(code3),
        .cmd_ready_i(rdy3), .stop_o(stop3));

    always @(negedge clk) begin
        if (rst_n && stop2) stop2_cnt++;
        if (rst_n && stop3) stop3_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Two-wire start pulse: a fall with the bit clock high, held for n clocks.
    task automatic start2(input int n);
        sd = 1'b1; wait_n(2);
        sd = 1'b0; wait_n(n);
    endtask

    // Shift nbits of c, MSB first; data changes only while the bit clock is low.
    task automatic bits(input logic [7:0] c, input int nbits);
        sd = c[7]; wait_n(2);
        for (int i = 7; i > 7 - nbits; i--) begin
            si = 1'b0; wait_n(2);
            sd = (i > 0) ? c[i-1] : 1'b1; wait_n(2);
            si = 1'b1; wait_n(3);
        end
    endtask

    task automatic frame2(input logic [7:0] c);
        start2(START_CLKS + 3); bits(c, 8); sd = 1'b1; wait_n(6);
    endtask

    task automatic frame3(input logic [7:0] c);
        st3 = 1'b0; wait_n(3); bits(c, 8); st3 = 1'b1; sd = 1'b1; wait_n(6);
    endtask

    task automatic accept2; rdy2 = 1'b1; wait_n(1); rdy2 = 1'b0; endtask
    task automatic accept3; rdy3 = 1'b1; wait_n(1); rdy3 = 1'b0; endtask

    // Expected outcome of one code, computed from the code value.
    task automatic judge(input bit three, input logic [7:0] c, input int stop_before);
        bit phrase = (c != 8'h00) && (c < 8'hF8);
        logic v = three ? val3 : val2;
        logic n = three ? nar3 : nar2;
        logic [7:0] q = three ? code3 : code2;
        int ds = (three ? stop3_cnt : stop2_cnt) - stop_before;
        if (phrase) begin
            check(v && !n && q == c, "R2", "phrase latched", {v, q}, {1'b1, c});
            if (three) accept3(); else accept2();
            n = three ? nar3 : nar2;
            check(n == 1'b1, "R5", "nar after accept", n, 1);
        end else begin
            check(!v && n, c == 8'h00 ? "R4" : "R3", "no latch", v, 0);
        end
        check(ds == ((c == 8'h00) ? 1 : 0), c == 8'h00 ? "R4" : "R3",
              "stop pulses", ds, (c == 8'h00) ? 1 : 0);
    endtask

    initial begin
        int sb;
        wait_n(4);
        // R1: reset state
        check(nar2 && !val2 && !stop2 && nar3 && !val3 && !stop3, "R1",
              "reset outputs", {nar2, val2, stop2}, 3'b100);
        rst_n = 1'b1; wait_n(3);
        check(nar2 && !val2 && nar3 && !val3, "R1", "after reset", {nar2, val2}, 2'b10);

        // R2 R3 R4: every code through two-wire framing
        for (int c = 0; c < 256; c++) begin
            sb = stop2_cnt; frame2(8'(c)); judge(1'b0, 8'(c), sb);
        end
        // R10: bit-clock traffic while the strobe stayed high did nothing
        check(!val3 && stop3_cnt == 0, "R10", "three-wire idle with strobe high",
              {val3, 8'(stop3_cnt)}, 0);

        // R10 R2 R3 R4: every code through three-wire framing
        for (int c = 0; c < 256; c++) begin
            sb = stop3_cnt; frame3(8'(c)); judge(1'b1, 8'(c), sb);
        end

        // R8: one clock short of the threshold opens no frame
        start2(START_CLKS - 1); bits(8'hA5, 8); sd = 1'b1; wait_n(6);
        check(!val2, "R8", "short start pulse ignored", val2, 0);
        // R8: exactly the threshold opens a frame
        start2(START_CLKS); bits(8'hA5, 8); sd = 1'b1; wait_n(6);
        check(val2 && code2 == 8'hA5, "R8", "threshold start", code2, 8'hA5);
        accept2(); wait_n(2);

        // R9: restart mid-frame discards partial bits
        start2(START_CLKS + 3); bits(8'hFF, 3);
        start2(START_CLKS + 3); bits(8'h3C, 8); sd = 1'b1; wait_n(6);
        check(val2 && code2 == 8'h3C, "R9", "restart keeps new frame", code2, 8'h3C);
        accept2(); wait_n(2);

        // R7: surplus bit clocks after the eighth are ignored
        start2(START_CLKS + 3); bits(8'h5A, 8); bits(8'h00, 4); sd = 1'b1; wait_n(6);
        check(val2 && code2 == 8'h5A, "R7", "extra clocks ignored", code2, 8'h5A);
        accept2(); wait_n(2);
        bits(8'h00, 8); sd = 1'b1; wait_n(6);
        check(!val2 && nar2, "R7", "no frame without start", val2, 0);

        // R6: a phrase against a full latch is dropped
        frame2(8'h11); frame2(8'h22);
        check(val2 && code2 == 8'h11, "R6", "held code kept", code2, 8'h11);
        // R5: code holds while ready stays low
        wait_n(20);
        check(val2 && code2 == 8'h11 && !nar2, "R5", "hold without ready", code2, 8'h11);
        // R4: stop empties the pending code
        sb = stop2_cnt; frame2(8'h00);
        check(!val2 && nar2, "R4", "stop clears latch", val2, 0);
        check(stop2_cnt - sb == 1, "R4", "single stop pulse", stop2_cnt - sb, 1);

        // R11: strobe raised mid-frame discards partial bits
        st3 = 1'b0; wait_n(3); bits(8'hFF, 5); st3 = 1'b1; sd = 1'b1; wait_n(4);
        frame3(8'h42);
        check(val3 && code3 == 8'h42, "R11", "abort then fresh frame", code3, 8'h42);
        accept3(); wait_n(2);
        // R11: partial frame alone produces nothing
        st3 = 1'b0; wait_n(3); bits(8'h77, 7); st3 = 1'b1; sd = 1'b1; wait_n(6);
        check(!val3 && nar3, "R11", "partial frame dropped", val3, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule